// File: doc/BRIEF.md
# Expanding opcode instruction decoder

This block decodes a 16-bit instruction word for a machine with sixteen general registers. The opcode is not fixed in length. It grows four bits at a time, and escape values in a 4-bit field say that the opcode carries on into the next field to the right. One word format therefore holds instructions with three, two, one or zero register operands. The encoding gives 14 three-operand, 30 two-operand, 30 one-operand and 32 zero-operand instructions, and together these cover every one of the 65536 words exactly once.

For each word the decoder reports three things. It gives the operand count as a class code, a dense opcode index that counts from zero within that class, and the register numbers for the operand fields, each with a valid flag. The decode logic is combinational. A build parameter `REG_OUT_EN` adds a single output register stage, with a synchronous active-low reset, so that the decoder can sit in a pipeline. By default the stage is present.

Top module: `opcode_escape_decoder`

## Requirements
- R1: When `instrIn[15:12]` is from 0 to 13, `opClass` is 3 and `opIndex` equals `instrIn[15:12]`. `regD`, `regS1` and `regS2` are then `instrIn[11:8]`, `instrIn[7:4]` and `instrIn[3:0]`, and all three are valid.
- R2: When `instrIn[15:12]` is 14, `opClass` is 2 and `opIndex` equals `instrIn[11:8]` (0 to 15). `regD` is `instrIn[7:4]` and `regS1` is `instrIn[3:0]`.
- R3: When `instrIn[15:12]` is 15 and `instrIn[11:8]` is from 0 to 13, `opClass` is 2 and `opIndex` is 16 plus `instrIn[11:8]`. The registers are the same as in R2.
- R4: When `instrIn[15:8]` is 8'hFE, `opClass` is 1, `opIndex` equals `instrIn[7:4]` and `regD` is `instrIn[3:0]`.
- R5: When `instrIn[15:8]` is 8'hFF and `instrIn[7:4]` is from 0 to 13, `opClass` is 1, `opIndex` is 16 plus `instrIn[7:4]` and `regD` is `instrIn[3:0]`.
- R6: When `instrIn[15:5]` is all ones, `opClass` is 0 and `opIndex` equals `instrIn[4:0]`, which spans 0 to 31.
- R7: The number of asserted register-valid flags equals `opClass`. Valid flags are filled in the order `regD`, `regS1`, `regS2`. A register output whose flag is low reads zero.
- R8: When `REG_OUT_EN` is 1, the outputs show the decode of the word that was present at the previous rising clock edge. While `rstN` is low at a rising edge, every output is cleared to zero, whatever the value of `instrIn`.
- R9: The decode is total and unique. Over all 65536 words, `opClass` 3, 2, 1 and 0 occur 57344, 7680, 480 and 32 times. `opIndex` always stays below the class size: 14, 30, 30 and 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Synchronous active-low reset of the output register |
| instrIn | input | 16 | Instruction word to decode |
| opClass | output | 2 | Number of register operands (0 to 3) |
| opIndex | output | 5 | Dense opcode index within the class |
| regD | output | 4 | First register operand |
| regS1 | output | 4 | Second register operand |
| regS2 | output | 4 | Third register operand |
| regDValid | output | 1 | regD holds a register number |
| regS1Valid | output | 1 | regS1 holds a register number |
| regS2Valid | output | 1 | regS2 holds a register number |

## Verification
The bench goes after the edges between prefix levels. These are the words whose leading field is 13, 14 or 15 at each depth, such as 16'hDFFF, 16'hE000, 16'hFDFF, 16'hFE00, 16'hFFDF, 16'hFFE0 and 16'hFFFF. A decoder that treats 14 and 15 the same would miscount a class and break the occurrence totals. A decoder that forgets the upper bank would put two opcodes on one index. A decoder that misplaces operand fields would send opcode bits out as register numbers, or raise a valid flag on a field that holds opcode bits. Resetting in the middle of a run while the input is non-zero shows whether the reset really overrides the decode. The one-word pipeline shift shows whether an output stage is missing or doubled.

// File: rtl/opcode_escape_pkg.sv
package opcode_escape_pkg;
  localparam int WORD_W     = 16;
  localparam int FIELD_W    = 4;
  localparam int NUM_FIELDS = WORD_W / FIELD_W;
  localparam int LEVEL_W    = $clog2(NUM_FIELDS);
  localparam int INDEX_W    = FIELD_W + 1;

  // all ones: opcode continues and the index moves to the upper bank
  localparam logic [FIELD_W-1:0] ESC_CONT = '1;
  // all ones minus one: next field is a full lower-bank index
  localparam logic [FIELD_W-1:0] ESC_LAST = FIELD_W'(ESC_CONT - 1'b1);

  typedef struct packed {
    logic [LEVEL_W-1:0] level;      // number of prefix fields before the index field
    logic               upperBank;  // index is offset by 2**FIELD_W
  } dec_strobe_t;

  typedef struct packed {
    logic [LEVEL_W-1:0] opClass;
    logic [INDEX_W-1:0] opIndex;
    logic [FIELD_W-1:0] regD;
    logic [FIELD_W-1:0] regS1;
    logic [FIELD_W-1:0] regS2;
    logic               regDValid;
    logic               regS1Valid;
    logic               regS2Valid;
  } dec_result_t;
endpackage

// File: rtl/opcode_escape_ctrl.sv
module opcode_escape_ctrl
  import opcode_escape_pkg::*;
(
  input  logic [WORD_W-1:0] instrIn,
  output dec_strobe_t       strobe
);

  // Walk the fields from the most significant one. A field below ESC_LAST
  // ends the opcode at that field. ESC_LAST ends it one field later in the
  // lower bank. ESC_CONT moves on to the next field in the upper bank.
  always_comb begin
    logic done;
    done             = 1'b0;
    strobe.level     = LEVEL_W'(NUM_FIELDS - 1);
    strobe.upperBank = 1'b0;
    for (int i = 0; i < NUM_FIELDS - 1; i++) begin
      if (!done) begin
        if (instrIn[(NUM_FIELDS-1-i)*FIELD_W +: FIELD_W] == ESC_CONT) begin
          strobe.upperBank = 1'b1;
        end else if (instrIn[(NUM_FIELDS-1-i)*FIELD_W +: FIELD_W] == ESC_LAST) begin
          strobe.level     = LEVEL_W'(i + 1);
          strobe.upperBank = 1'b0;
          done             = 1'b1;
        end else begin
          strobe.level = LEVEL_W'(i);
          done         = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/opcode_escape_dpath.sv
module opcode_escape_dpath
  import opcode_escape_pkg::*;
#(
  parameter bit REG_OUT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] instrIn,
  input  dec_strobe_t       strobe,
  output dec_result_t       result
);

  logic [FIELD_W-1:0] field [NUM_FIELDS];
  dec_result_t        nxt;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign field[g] = instrIn[g*FIELD_W +: FIELD_W];
  end

  // position of the index field, counted from the least significant field;
  // this also equals the number of operand fields below it
  logic [LEVEL_W-1:0] idxSel;
  logic [LEVEL_W-1:0] dSel;
  logic [LEVEL_W-1:0] s1Sel;
  logic [LEVEL_W-1:0] s2Sel;

  always_comb begin
    idxSel = LEVEL_W'(NUM_FIELDS - 1) - strobe.level;
    dSel   = idxSel - LEVEL_W'(1);
    s1Sel  = idxSel - LEVEL_W'(2);
    s2Sel  = idxSel - LEVEL_W'(3);

    nxt         = '0;
    nxt.opClass = idxSel;
    nxt.opIndex = {strobe.upperBank, field[idxSel]};
    if (idxSel >= LEVEL_W'(1)) begin
      nxt.regD      = field[dSel];
      nxt.regDValid = 1'b1;
    end
    if (idxSel >= LEVEL_W'(2)) begin
      nxt.regS1      = field[s1Sel];
      nxt.regS1Valid = 1'b1;
    end
    if (idxSel >= LEVEL_W'(3)) begin
      nxt.regS2      = field[s2Sel];
      nxt.regS2Valid = 1'b1;
    end
  end

  if (REG_OUT_EN) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) result <= '0;
      else       result <= nxt;
    end
  end else begin : g_comb
    assign result = nxt;
  end

endmodule

// File: rtl/opcode_escape_decoder.sv
module opcode_escape_decoder
  import opcode_escape_pkg::*;
#(
  parameter bit REG_OUT_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [WORD_W-1:0]   instrIn,
  output logic [LEVEL_W-1:0]  opClass,
  output logic [INDEX_W-1:0]  opIndex,
  output logic [FIELD_W-1:0]  regD,
  output logic [FIELD_W-1:0]  regS1,
  output logic [FIELD_W-1:0]  regS2,
  output logic                regDValid,
  output logic                regS1Valid,
  output logic                regS2Valid
);

  dec_strobe_t strobe;
  dec_result_t result;

  opcode_escape_ctrl ctrl_i (
    .instrIn (instrIn),
    .strobe  (strobe)
  );

  opcode_escape_dpath #(.REG_OUT_EN(REG_OUT_EN)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .instrIn (instrIn),
    .strobe  (strobe),
    .result  (result)
  );

  assign opClass    = result.opClass;
  assign opIndex    = result.opIndex;
  assign regD       = result.regD;
  assign regS1      = result.regS1;
  assign regS2      = result.regS2;
  assign regDValid  = result.regDValid;
  assign regS1Valid = result.regS1Valid;
  assign regS2Valid = result.regS2Valid;

endmodule

// File: rtl/opcode_escape_chk.sv
module opcode_escape_chk
  import opcode_escape_pkg::*;
#(
  parameter bit REG_OUT_EN = 1'b1
) (
  input logic                clk,
  input logic                rstN,
  input logic [WORD_W-1:0]   instrIn,
  input logic [LEVEL_W-1:0]  opClass,
  input logic [INDEX_W-1:0]  opIndex,
  input logic [FIELD_W-1:0]  regD,
  input logic [FIELD_W-1:0]  regS1,
  input logic [FIELD_W-1:0]  regS2,
  input logic                regDValid,
  input logic                regS1Valid,
  input logic                regS2Valid
);

  // word the present outputs belong to, and whether that word is meaningful
  logic [WORD_W-1:0] seen;
  logic              primed;

  if (REG_OUT_EN) begin : g_lat
    always_ff @(posedge clk) begin
      seen   <= instrIn;
      primed <= rstN;
    end
  end else begin : g_nolat
    assign seen   = instrIn;
    assign primed = rstN;
  end

  assert_three_op_R1: assert property (@(posedge clk) disable iff (!rstN)
    primed && seen[15:12] < 4'd14 |->
      opClass == 2'd3 && opIndex == {1'b0, seen[15:12]} &&
      regD == seen[11:8] && regS1 == seen[7:4] && regS2 == seen[3:0]);

  assert_lower_two_R2: assert property (@(posedge clk) disable iff (!rstN)
    primed && seen[15:12] == 4'd14 |->
      opClass == 2'd2 && opIndex == {1'b0, seen[11:8]} &&
      regD == seen[7:4] && regS1 == seen[3:0]);

  assert_upper_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    primed && seen[15:8] == 8'hFF && seen[7:4] < 4'd14 |->
      opClass == 2'd1 && opIndex == {1'b1, seen[7:4]} && regD == seen[3:0]);

  assert_zero_op_R6: assert property (@(posedge clk) disable iff (!rstN)
    primed && seen[15:5] == 11'h7FF |-> opClass == 2'd0 && opIndex == seen[4:0]);

  assert_valid_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> $countones({regDValid, regS1Valid, regS2Valid}) == 32'(opClass));

  assert_valid_nest_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regS2Valid |-> regS1Valid) and (regS1Valid |-> regDValid));

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!regDValid |-> regD == '0) and (!regS1Valid |-> regS1 == '0) and
    (!regS2Valid |-> regS2 == '0));

  assert_index_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (opClass == 2'd3) ? (opIndex < 5'd14) :
               (opClass == 2'd0) ? 1'b1 : (opIndex < 5'd30));

endmodule

bind opcode_escape_decoder opcode_escape_chk #(.REG_OUT_EN(REG_OUT_EN)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .instrIn    (instrIn),
  .opClass    (opClass),
  .opIndex    (opIndex),
  .regD       (regD),
  .regS1      (regS1),
  .regS2      (regS2),
  .regDValid  (regDValid),
  .regS1Valid (regS1Valid),
  .regS2Valid (regS2Valid)
);

// File: tb/opcode_escape_decoder_tb.sv
module opcode_escape_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] instrIn = 16'h0000;
  logic [1:0]  opClass;
  logic [4:0]  opIndex;
  logic [3:0]  regD, regS1, regS2;
  logic        regDValid, regS1Valid, regS2Valid;

  int checks = 0;
  int errors = 0;
  int classCount [4];
  bit countOn = 1'b0;
  bit havePrev = 1'b0;
  logic [15:0] prevWord = 16'h0000;

  always #2 clk = ~clk;  // 250 MHz

  opcode_escape_decoder dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .instrIn    (instrIn),
    .opClass    (opClass),
    .opIndex    (opIndex),
    .regD       (regD),
    .regS1      (regS1),
    .regS2      (regS2),
    .regDValid  (regDValid),
    .regS1Valid (regS1Valid),
    .regS2Valid (regS2Valid)
  );

  // packed as {class, index, regD, regS1, regS2, vD, vS1, vS2}
  function automatic logic [21:0] refDecode(input logic [15:0] w);
    logic [3:0] a, b, c, d;
    logic [1:0] cls;
    logic [4:0] idx;
    logic [3:0] rd, rs1, rs2;
    logic [2:0] v;
    a = w[15:12]; b = w[11:8]; c = w[7:4]; d = w[3:0];
    rd = 4'd0; rs1 = 4'd0; rs2 = 4'd0;
    if (a <= 4'd13) begin
      cls = 2'd3; idx = {1'b0, a}; rd = b; rs1 = c; rs2 = d; v = 3'b111;
    end else if (a == 4'd14) begin
      cls = 2'd2; idx = {1'b0, b}; rd = c; rs1 = d; v = 3'b110;
    end else if (b <= 4'd13) begin
      cls = 2'd2; idx = 5'd16 + {1'b0, b}; rd = c; rs1 = d; v = 3'b110;
    end else if (b == 4'd14) begin
      cls = 2'd1; idx = {1'b0, c}; rd = d; v = 3'b100;
    end else if (c <= 4'd13) begin
      cls = 2'd1; idx = 5'd16 + {1'b0, c}; rd = d; v = 3'b100;
    end else begin
      cls = 2'd0; idx = {c[0], d}; v = 3'b000;
    end
    return {cls, idx, rd, rs1, rs2, v};
  endfunction

  function automatic string reqTag(input logic [15:0] w);
    if (w[15:12] <= 4'd13) return "R1";
    if (w[15:12] == 4'd14) return "R2";
    if (w[11:8] <= 4'd13)  return "R3";
    if (w[11:8] == 4'd14)  return "R4";
    if (w[7:4] <= 4'd13)   return "R5";
    return "R6";
  endfunction

  function automatic logic [21:0] observed();
    return {opClass, opIndex, regD, regS1, regS2, regDValid, regS1Valid, regS2Valid};
  endfunction

  // R7 expectations are part of every refDecode comparison (valid flags, zeroed regs)
  task automatic checkWord(input logic [15:0] w);
    logic [21:0] exp, got;
    exp = refDecode(w);
    got = observed();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s/R7/R8 word=%h actual=%h expected=%h", reqTag(w), w, got, exp);
    end
    if (countOn) classCount[opClass]++;
  endtask

  // R8: word applied now is visible one edge later, checked at the next falling edge
  task automatic applyWord(input logic [15:0] w);
    @(negedge clk);
    if (havePrev) checkWord(prevWord);
    instrIn  = w;
    prevWord = w;
    havePrev = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (havePrev) checkWord(prevWord);
    havePrev = 1'b0;
  endtask

  task automatic checkCleared(input string what);
    checks++;
    if (observed() !== 22'd0) begin
      errors++;
      $display("FAIL R8 %s actual=%h expected=%h", what, observed(), 22'd0);
    end
  endtask

  task automatic checkEq(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] corners [14];
    int seedDummy;
    corners = '{16'h0000, 16'hDFFF, 16'hE000, 16'hEFFF, 16'hF000, 16'hFDFF,
                16'hFE00, 16'hFEFF, 16'hFF00, 16'hFFDF, 16'hFFE0, 16'hFFEF,
                16'hFFF0, 16'hFFFF};
    for (int k = 0; k < 4; k++) classCount[k] = 0;

    // R8: reset clears outputs even with a non-zero word present
    instrIn = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkCleared("initial reset");
    rstN = 1'b1;

    // directed edges between prefix levels (R1..R6)
    for (int k = 0; k < 14; k++) applyWord(corners[k]);
    flush();

    // exhaustive sweep, R9 occurrence counts
    countOn = 1'b1;
    for (int w = 0; w < 65536; w++) applyWord(w[15:0]);
    flush();
    countOn = 1'b0;
    checkEq("R9 class3 count", classCount[3], 57344);
    checkEq("R9 class2 count", classCount[2], 7680);
    checkEq("R9 class1 count", classCount[1], 480);
    checkEq("R9 class0 count", classCount[0], 32);

    // random words, biased toward the escape region
    seedDummy = int'($urandom(32'h00C0FFEE));
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] r;
      r = $urandom();
      if (k % 3 == 0) r[15:8] = 8'hFF;
      else if (k % 3 == 1) r[15:12] = 4'hF;
      applyWord(r);
    end
    flush();

    // R8: reset in the middle of a run overrides the decode
    @(negedge clk);
    rstN = 1'b0;
    instrIn = 16'h1234;
    @(negedge clk);
    checkCleared("mid-run reset");
    rstN = 1'b1;
    applyWord(16'hFE5A);
    applyWord(16'h1234);
    flush();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule